// File: doc/BRIEF.md
# Alternate-Byte Transfer Sequencer

This block carries out the split-register peripheral move of a processor with a 16-bit bus. Narrow 8-bit peripherals are often wired to one lane of such a bus, so their registers show up at every second byte address. The sequencer moves a 2-byte or 4-byte slice of a 32-bit data register to those bytes, or from them, with one single-byte bus cycle per byte. The most significant byte always sits at the lowest address.

The controlling sequencer presents the 16-bit instruction word, the 16-bit displacement from the extension word, the value of the address register and the value of the data register, and pulses `start_i`. The block decodes the word, latches everything it needs and enters `ST_ACCESS`. In that state it drives a request/acknowledge byte port once per byte. After the last acknowledge it moves to `ST_FINISH`, where it raises `done_o` for one cycle, and then returns to `ST_IDLE`. A load presents the merged register value on `result_o` during that cycle, qualified by `result_we_o`. The decoder outputs are combinational. They also tell the surrounding decoder when the word belongs to the bit-operation group that shares this opcode space.

Transitions: `ST_IDLE` to `ST_ACCESS` when start is accepted. `ST_ACCESS` stays in `ST_ACCESS` when a non-final byte is acknowledged. `ST_ACCESS` to `ST_FINISH` when the final byte is acknowledged. `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `abx_xfer_seq`

## Requirements
- R1: `hit_o` is 1 exactly when `(insn_i & 16'hF1F8)` equals 16'h0108, 16'h0148, 16'h0188 or 16'h01C8.
- R2: `bitop_o` is 1 when `(insn_i & 16'hF1C0)` equals 16'h0100, 16'h0140, 16'h0180 or 16'h01C0, but only if `hit_o` is 0. The transfer match wins over the bit-operation match.
- R3: `dreg_num_o` equals `insn_i[11:9]` and `areg_num_o` equals `insn_i[2:0]`.
- R4: The size is set by `insn_i[6]`: 1 gives 4 bytes and 0 gives 2 bytes. The direction is set by `insn_i[7]`: 1 writes memory (`mem_we_o`=1) and 0 reads memory.
- R5: The first byte address is `areg_i` plus `disp_i` sign-extended to 32 bits, modulo 2^32. Address, direction and write data stay stable while `mem_req_o` is high and `mem_ack_i` is low.
- R6: Each later byte address is the previous one plus 2, wrapping modulo 2^32. Exactly 2 or 4 acknowledged accesses take place. No address step follows the last one.
- R7: On a store, byte j (counting from 0) carries register bits `8*(N-1-j)+7 .. 8*(N-1-j)`, where N is the byte count. This puts the top byte of the selected size first.
- R8: On a load, the first byte read becomes the most significant byte of the result. A long load replaces all 32 bits. A word load gives `{dreg_i[31:16], b0, b1}`, with `dreg_i` taken at start.
- R9: `done_o` is high for exactly one cycle, the cycle after the final acknowledge, and `busy_o` is low in the cycle after it. `result_we_o` equals `done_o` on loads and is 0 on stores.
- R10: A start is ignored while `busy_o` is high, and it is ignored when `hit_o` is 0. An ignored start causes no request, and it leaves the running transfer's addresses, data and result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request from the controlling sequencer |
| insn_i | input | 16 | Instruction word |
| disp_i | input | 16 | Displacement from the extension word |
| areg_i | input | 32 | Address register value |
| dreg_i | input | 32 | Data register value |
| hit_o | output | 1 | Instruction is an alternate-byte transfer |
| bitop_o | output | 1 | Instruction belongs to the bit-operation group |
| dreg_num_o | output | 3 | Data register number |
| areg_num_o | output | 3 | Address register number |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Access acknowledge |
| mem_rdata_i | input | 8 | Read byte |
| result_o | output | 32 | Updated register value on a load |
| result_we_o | output | 1 | Write strobe for `result_o` |

## Verification
The bench sweeps the whole 16-bit instruction space through the decoder. A design that let the bit-operation pattern shadow the transfer, or that widened the mask, would raise the wrong flag for some word. Every size/direction combination runs against zero, one and two cycles of acknowledge latency, with negative displacements and a base that wraps past 2^32. A design that zero-extended the displacement, stepped after the last byte, emitted bytes least significant first or cleared the upper half on a word load would produce a mismatched address or value. A second start, carrying a different instruction, is injected in the middle of every transfer. A design that re-sampled its inputs would change course partway through the sequence.

// File: rtl/abx_pkg.sv
package abx_pkg;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 32;
    localparam int INSN_W  = 16;
    localparam int DISP_W  = 16;
    localparam int RNUM_W  = 3;
    localparam int STRIDE  = 2;
    localparam int LONG_BYTES = REG_W / BYTE_W;
    localparam int WORD_BYTES = LONG_BYTES / 2;
    localparam int CNT_W      = $clog2(LONG_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2
    } abx_state_e;

    typedef struct packed {
        logic              hit;
        logic              bitop;
        logic              is_long;
        logic              to_mem;
        logic [RNUM_W-1:0] dnum;
        logic [RNUM_W-1:0] anum;
    } abx_dec_t;
endpackage

// File: rtl/abx_decode.sv
module abx_decode
    import abx_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output abx_dec_t          dec_o
);
    localparam logic [INSN_W-1:0] XFER_MASK  = 16'hF1F8;
    localparam logic [INSN_W-1:0] XFER_BASE  = 16'h0108;
    localparam logic [INSN_W-1:0] BITOP_MASK = 16'hF1C0;
    localparam logic [INSN_W-1:0] BITOP_BASE = 16'h0100;
    localparam int NVAR = 4;

    logic [NVAR-1:0] xfer_v;
    logic [NVAR-1:0] bitop_v;

    for (genvar k = 0; k < NVAR; k++) begin : g_var
        localparam logic [INSN_W-1:0] OPB = INSN_W'(k) << 6;
        assign xfer_v[k]  = (insn_i & XFER_MASK)  == (XFER_BASE  | OPB);
        assign bitop_v[k] = (insn_i & BITOP_MASK) == (BITOP_BASE | OPB);
    end

    always_comb begin
        dec_o.hit     = |xfer_v;
        dec_o.bitop   = (|bitop_v) & ~(|xfer_v);
        dec_o.is_long = insn_i[6];
        dec_o.to_mem  = insn_i[7];
        dec_o.dnum    = insn_i[11:9];
        dec_o.anum    = insn_i[2:0];
    end
endmodule

// File: rtl/abx_addr_gen.sv
module abx_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STRIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i + disp_ext;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_W'(STRIDE);
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/abx_byte_lane.sv
module abx_byte_lane #(
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              is_long_i,
    input  logic [REG_W-1:0]  dreg_i,
    input  logic              long_q_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [BYTE_W-1:0] wbyte_o,
    output logic [REG_W-1:0]  result_o
);
    localparam int HALF_W = REG_W / 2;

    logic [REG_W-1:0]  sh_q;
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            hi_q <= '0;
        end else if (load_i) begin
            sh_q <= is_long_i ? dreg_i : {dreg_i[HALF_W-1:0], {HALF_W{1'b0}}};
            hi_q <= dreg_i[REG_W-1:HALF_W];
        end else if (shift_i) begin
            sh_q <= {sh_q[REG_W-BYTE_W-1:0], rdata_i};
        end
    end

    assign wbyte_o  = sh_q[REG_W-1 -: BYTE_W];
    assign result_o = long_q_i ? sh_q : {hi_q, sh_q[HALF_W-1:0]};
endmodule

// File: rtl/abx_xfer_seq.sv
module abx_xfer_seq
    import abx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       insn_i,
    input  logic [15:0]       disp_i,
    input  logic [31:0]       areg_i,
    input  logic [31:0]       dreg_i,
    output logic              hit_o,
    output logic              bitop_o,
    output logic [2:0]        dreg_num_o,
    output logic [2:0]        areg_num_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [31:0]       result_o,
    output logic              result_we_o
);
    abx_dec_t          dec;
    abx_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_idx;
    logic              long_q, store_q;
    logic              accept, last, beat, step;
    logic [BYTE_W-1:0] wbyte;

    abx_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    assign accept   = (state_q == ST_IDLE) && start_i && dec.hit;
    assign last_idx = long_q ? CNT_W'(LONG_BYTES - 1) : CNT_W'(WORD_BYTES - 1);
    assign last     = (cnt_q == last_idx);
    assign beat     = (state_q == ST_ACCESS) && mem_ack_i;
    assign step     = beat && !last;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ACCESS;
            ST_ACCESS: if (beat && last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            long_q  <= 1'b0;
            store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q   <= '0;
                long_q  <= dec.is_long;
                store_q <= dec.to_mem;
            end else if (step) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    abx_addr_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .STRIDE (STRIDE)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .base_i (areg_i),
        .disp_i (disp_i),
        .step_i (step),
        .addr_o (mem_addr_o)
    );

    abx_byte_lane #(
        .REG_W  (REG_W),
        .BYTE_W (BYTE_W)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .is_long_i (dec.is_long),
        .dreg_i    (dreg_i),
        .long_q_i  (long_q),
        .shift_i   (beat),
        .rdata_i   (mem_rdata_i),
        .wbyte_o   (wbyte),
        .result_o  (result_o)
    );

    // outputs
    always_comb begin
        hit_o       = dec.hit;
        bitop_o     = dec.bitop;
        dreg_num_o  = dec.dnum;
        areg_num_o  = dec.anum;
        busy_o      = (state_q != ST_IDLE);
        mem_req_o   = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACCESS: mem_req_o = 1'b1;
            ST_FINISH: done_o    = 1'b1;
            default:   ;
        endcase
        mem_we_o    = mem_req_o && store_q;
        mem_wdata_o = mem_we_o ? wbyte : '0;
        result_we_o = done_o && !store_q;
    end
endmodule

// File: rtl/abx_xfer_seq_chk.sv
module abx_xfer_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        hit_o,
    input logic        bitop_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic [7:0]  mem_wdata_o,
    input logic        mem_ack_i,
    input logic        result_we_o
);
    a_r2_match_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && bitop_o));

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    a_r6_stride_two: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) ##1 mem_req_o |-> mem_addr_o == $past(mem_addr_o) + 32'd2);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(mem_req_o && mem_ack_i));

    a_r9_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        result_we_o |-> done_o);

    a_r10_no_hit_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !hit_o) |=> !busy_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);
endmodule

bind abx_xfer_seq abx_xfer_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .hit_o       (hit_o),
    .bitop_o     (bitop_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .result_we_o (result_we_o)
);

// File: tb/abx_xfer_seq_tb_top.sv
module abx_xfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] areg_i = '0;
    logic [31:0] dreg_i = '0;
    logic        hit_o, bitop_o, busy_o, done_o;
    logic [2:0]  dreg_num_o, areg_num_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [7:0]  mem_rdata_i = '0;
    logic [31:0] result_o;
    logic        result_we_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    abx_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .disp_i(disp_i), .areg_i(areg_i), .dreg_i(dreg_i),
        .hit_o(hit_o), .bitop_o(bitop_o), .dreg_num_o(dreg_num_o),
        .areg_num_o(areg_num_o), .busy_o(busy_o), .done_o(done_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .result_o(result_o), .result_we_o(result_we_o)
    );

    function automatic logic [7:0] mem_model(input logic [31:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] insn, input logic [31:0] areg,
                          input logic [15:0] disp, input logic [31:0] dreg,
                          input int lat);
        int          nb;
        bit          store;
        logic [31:0] a0, exp_res;
        int          j, wait_n;
        bit          finished;
        nb     = insn[6] ? 4 : 2;
        store  = insn[7];
        a0     = areg + {{16{disp[15]}}, disp};
        j      = 0;
        wait_n = 0;
        finished = 0;
        @(negedge clk);
        insn_i = insn; areg_i = areg; disp_i = disp; dreg_i = dreg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 40 && !finished; k++) begin
            if (k == 1) begin
                // R10: a second, different transfer while busy must be ignored
                insn_i = 16'h0FCF ^ {8'h00, insn[7:6], 6'h00};
                areg_i = ~areg; disp_i = ~disp; dreg_i = ~dreg; start_i = 1'b1;
            end else if (k == 2) begin
                start_i = 1'b0;
            end
            mem_ack_i = 1'b0;
            if (done_o) begin
                check(j == nb, "R6 access count", j, nb);
                if (store) begin
                    check(result_we_o == 1'b0, "R9 no result strobe on store", result_we_o, 0);
                end else begin
                    exp_res = 0;
                    for (int b = 0; b < nb; b++)
                        exp_res = {exp_res[23:0], mem_model(a0 + 32'(2 * b))};
                    if (nb == 2) exp_res = {dreg[31:16], exp_res[15:0]};
                    check(result_we_o && result_o == exp_res, "R8 load result",
                          {31'd0, result_we_o, result_o}, {32'd1, exp_res});
                end
                @(negedge clk);
                check(!done_o && !busy_o, "R9 done single pulse", {done_o, busy_o}, 0);
                finished = 1;
            end else if (mem_req_o) begin
                if (wait_n == lat) begin
                    logic [31:0] ea;
                    logic [7:0]  ed;
                    ea = a0 + 32'(2 * j);
                    ed = 8'((dreg >> (8 * (nb - 1 - j))));
                    check(mem_addr_o == ea, j == 0 ? "R5 first address" : "R6 stepped address",
                          mem_addr_o, ea);
                    check(mem_we_o == store, "R4 direction", mem_we_o, store);
                    if (store) check(mem_wdata_o == ed, "R7 store byte order", mem_wdata_o, ed);
                    mem_rdata_i = mem_model(mem_addr_o);
                    mem_ack_i   = 1'b1;
                    wait_n = 0;
                    j++;
                end else begin
                    wait_n++;
                end
            end else begin
                check(0, "R9 request dropped before done", 0, 1);
                finished = 1;
            end
            if (!finished) @(negedge clk);
        end
        mem_ack_i = 1'b0;
        start_i   = 1'b0;
        if (!finished) check(0, "R9 transfer never completed", 0, 1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        logic [15:0] disps [3];
        logic [31:0] datas [3];
        bases = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h8000_0001};
        disps = '{16'hFFF0, 16'h0002, 16'h7FFE};
        datas = '{32'hA1B2_C3D4, 32'h1122_3344, 32'hF00D_BEEF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !mem_req_o && !result_we_o, "R9 reset state",
              {busy_o, done_o, mem_req_o, result_we_o}, 0);

        // R1 R2 R3 decode sweep over every instruction word
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] w;
            bit eh, eb;
            w = 16'(i);
            insn_i = w;
            #1;
            eh = (w[15:12] == 4'h0) && w[8] && (w[5:3] == 3'b001);
            eb = (w[15:12] == 4'h0) && w[8] && (w[5:3] != 3'b001);
            if (hit_o != eh || bitop_o != eb || dreg_num_o != w[11:9] || areg_num_o != w[2:0])
                check(0, "R1 R2 R3 decode", {hit_o, bitop_o, dreg_num_o, areg_num_o},
                      {eh, eb, w[11:9], w[2:0]});
            else
                n_cmp++;
        end

        // R10: start without a match does nothing
        @(negedge clk);
        insn_i = 16'h0140; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check(!busy_o && !mem_req_o, "R10 non-matching start ignored", {busy_o, mem_req_o}, 0);
            @(negedge clk);
        end

        // R4 R5 R6 R7 R8: every mode, several operands, latencies 0..2
        for (int op = 0; op < 4; op++)
            for (int s = 0; s < 3; s++)
                for (int lat = 0; lat < 3; lat++) begin
                    logic [15:0] w;
                    w = 16'h0108 | (16'((s * 3 + lat) % 8) << 9) | (16'(op) << 6) | 16'(s + lat);
                    run_op(w, bases[s], disps[(s + lat) % 3], datas[(s + op) % 3], lat);
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule